// File: doc/BRIEF.md
# Single-Slope Fast PWM Timer

This block is an 8-bit up-counter that drives up to two waveform outputs in single-slope pulse-width modulation. The counter advances once per prescaled tick from zero to a ceiling, then returns to zero on the next tick. The ceiling is either the full 8-bit range or the live value of compare channel A. Each channel compares the counter with its own live compare value. Depending on its output mode, the channel either drives a straight PWM wave, drives an inverted PWM wave, toggles on every match, or holds a level that software sets.

Software programs the block through a small write port. Compare values land in a staging buffer and become live only at the wrap tick, so a mid-period update cannot produce a runt pulse. Sticky flags report the wrap and each channel's match, and a write of one clears them. The tick source is an internal divider that software selects. It divides the clock by 1, 8, 32, 64, 128, 256 or 1024, and it can also stop the count.

Top module: `fpwm_timer`

## Requirements
- R1: On each tick the count rises by one. When the count equals the ceiling, that tick returns it to 0 instead.
- R2: Control register (address 0) bit 0 picks the ceiling: 0 gives 255, 1 gives the live compare value of channel A.
- R3: Control bits [3:1] pick the tick divider: 0 stops, and 1 to 7 give one tick every 1, 8, 32, 64, 128, 256 or 1024 clocks. Writing the control register restarts the divider, so the first tick lands on the N-th clock edge after the write edge.
- R4: Output mode 2 (straight PWM) drives the wave low on a match tick and high on the wrap tick. When both fall on the same tick, high wins.
- R5: Output mode 3 (inverted PWM) drives the wave high on a match tick and low on the wrap tick. When both fall on the same tick, low wins.
- R6: Output mode 1 inverts the wave on every match tick.
- R7: Output mode 0 makes the wave follow a software level bit. The mode register (address 3) holds channel A mode in [1:0], channel B mode in [3:2], the channel A level in bit 4 and the channel B level in bit 5.
- R8: Writes to address 1 (channel A) or address 2 (channel B) reach a staging buffer only. The live compare value takes the buffer on the wrap tick and at no other time.
- R9: The overflow flag is set on the wrap tick. A channel's match flag is set on a tick where the count equals that channel's live compare value.
- R10: Writing address 4 clears flags where the data bit is 1: bit 0 is overflow, bit 1 is channel A, bit 2 is channel B. A set in the same cycle takes priority over the clear.
- R11: After reset the count, all flags and both waves are 0, the divider is stopped and both channels are in mode 0.
- R12: With a ceiling of 255 in mode 2, a live compare of 0 gives one high tick every 256 ticks, and a live compare of 255 gives a wave that stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 8 | Register write data |
| count_o | output | 8 | Current counter value |
| ovf_o | output | 1 | Sticky overflow flag |
| match_o | output | 2 | Sticky compare-match flags, bit i for channel i |
| wave_o | output | 2 | Waveform outputs, bit i for channel i |

## Verification
Two events can fall on the same cycle here. One is a software clear of a flag landing on the tick where that flag is set again. The other is a compare match landing on the wrap tick, which happens when the compare value equals the ceiling. The bench holds a continuous clear write across several periods so that clears meet every match and wrap tick. It also programs compare values of 255 and, in ceiling-from-A mode, makes channel A match exactly at the wrap. A cycle model in the bench, built from the priority rules, predicts every output, and a monitor compares each predicted item with the ports. Set-over-clear and wrap-over-match are therefore judged on every cycle where they meet.

// File: rtl/fpwm_pkg.sv
package fpwm_pkg;

    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
    localparam logic [ADDR_W-1:0] A_CMPA  = 3'd1;
    localparam logic [ADDR_W-1:0] A_CMPB  = 3'd2;
    localparam logic [ADDR_W-1:0] A_OMODE = 3'd3;
    localparam logic [ADDR_W-1:0] A_FLAGS = 3'd4;

    typedef enum logic [1:0] {
        OM_HOLD   = 2'd0,
        OM_TOGGLE = 2'd1,
        OM_STRAIT = 2'd2,
        OM_INVERT = 2'd3
    } outmode_e;

endpackage

// File: rtl/fpwm_prescale.sv
module fpwm_prescale #(
    parameter int PRE_W = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       restart,
    input  logic [2:0] sel,
    output logic       tick
);

    function automatic logic [PRE_W-1:0] div_mask(input logic [2:0] s);
        int sh;
        case (s)
            3'd2:    sh = 3;
            3'd3:    sh = 5;
            3'd4:    sh = 6;
            3'd5:    sh = 7;
            3'd6:    sh = 8;
            3'd7:    sh = 10;
            default: sh = 0;
        endcase
        return PRE_W'((1 << sh) - 1);
    endfunction

    logic [PRE_W-1:0] pre_d, pre_q;
    logic [PRE_W-1:0] mask;

    always_comb begin
        mask  = div_mask(sel);
        tick  = (sel != 3'd0) && ((pre_q & mask) == mask);
        pre_d = pre_q;
        if (restart)
            pre_d = '0;
        else if (sel != 3'd0)
            pre_d = pre_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end

    // R3
    stopped_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == 3'd0) |-> !tick);

endmodule

// File: rtl/fpwm_counter.sv
module fpwm_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             top_sel,
    input  logic [CNT_W-1:0] cmpa_live,
    output logic [CNT_W-1:0] count,
    output logic             wrap
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic [CNT_W-1:0] ceiling;

    always_comb begin
        st_d    = st_q;
        ceiling = top_sel ? cmpa_live : CNT_MAX;
        wrap    = tick && (st_q.cnt == ceiling);
        if (tick)
            st_d.cnt = wrap ? '0 : st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count = st_q.cnt;

    // R1
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wrap) |=> (count == $past(count) + 1'b1));

    // R1
    count_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (count == '0));

    // R3
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(count));

endmodule

// File: rtl/fpwm_channel.sv
module fpwm_channel
    import fpwm_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             wrap,
    input  logic [CNT_W-1:0] count,
    input  logic             load_buf,
    input  logic [CNT_W-1:0] buf_data,
    input  outmode_e         mode,
    input  logic             idle_lvl,
    input  logic             flag_clr,
    output logic [CNT_W-1:0] live_o,
    output logic             wave_o,
    output logic             flag_o
);

    typedef struct packed {
        logic [CNT_W-1:0] stage;
        logic [CNT_W-1:0] live;
        logic             wave;
        logic             flag;
    } ch_state_t;

    ch_state_t st_d, st_q;
    logic      hit;

    always_comb begin
        st_d = st_q;
        hit  = tick && (count == st_q.live);

        if (load_buf)
            st_d.stage = buf_data;
        if (wrap)
            st_d.live = st_q.stage;

        if (hit)
            st_d.flag = 1'b1;
        else if (flag_clr)
            st_d.flag = 1'b0;

        unique case (mode)
            OM_HOLD:   st_d.wave = idle_lvl;
            OM_TOGGLE: st_d.wave = hit ? ~st_q.wave : st_q.wave;
            OM_STRAIT: begin
                if (wrap)     st_d.wave = 1'b1;
                else if (hit) st_d.wave = 1'b0;
            end
            OM_INVERT: begin
                if (wrap)     st_d.wave = 1'b0;
                else if (hit) st_d.wave = 1'b1;
            end
            default:   st_d.wave = st_q.wave;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign live_o = st_q.live;
    assign wave_o = st_q.wave;
    assign flag_o = st_q.flag;

    // R4
    strait_wrap_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && mode == OM_STRAIT) |=> wave_o);

    // R5
    invert_wrap_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && mode == OM_INVERT) |=> !wave_o);

    // R7
    hold_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == OM_HOLD) |=> (wave_o == $past(idle_lvl)));

    // R9
    match_flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && count == live_o) |=> flag_o);

endmodule

// File: rtl/fpwm_timer.sv
module fpwm_timer
    import fpwm_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int NCH   = 2,
    parameter int PRE_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [2:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] count_o,
    output logic             ovf_o,
    output logic [NCH-1:0]   match_o,
    output logic [NCH-1:0]   wave_o
);

    typedef struct packed {
        logic           top_sel;
        logic [2:0]     psel;
        logic [NCH-1:0] idle;
        logic [1:0]     mode0;
        logic [1:0]     mode1;
        logic           ovf;
    } top_state_t;

    top_state_t st_d, st_q;

    logic                 tick;
    logic                 wrap;
    logic                 ctrl_wr;
    logic                 flag_wr;
    logic [CNT_W-1:0]     live [NCH];
    logic [NCH-1:0]       load_buf;
    logic [NCH-1:0]       flag_clr;
    outmode_e             mode [NCH];

    always_comb begin
        st_d    = st_q;
        ctrl_wr = wr_en && (wr_addr == A_CTRL);
        flag_wr = wr_en && (wr_addr == A_FLAGS);

        if (ctrl_wr) begin
            st_d.top_sel = wr_data[0];
            st_d.psel    = wr_data[3:1];
        end
        if (wr_en && wr_addr == A_OMODE) begin
            st_d.mode0 = wr_data[1:0];
            st_d.mode1 = wr_data[3:2];
            st_d.idle  = wr_data[4 +: NCH];
        end

        if (wrap)
            st_d.ovf = 1'b1;
        else if (flag_wr && wr_data[0])
            st_d.ovf = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    fpwm_prescale #(.PRE_W(PRE_W)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (ctrl_wr),
        .sel     (st_q.psel),
        .tick    (tick)
    );

    fpwm_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .top_sel   (st_q.top_sel),
        .cmpa_live (live[0]),
        .count     (count_o),
        .wrap      (wrap)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        assign load_buf[i] = wr_en && (wr_addr == A_CMPA + 3'(i));
        assign flag_clr[i] = wr_en && (wr_addr == A_FLAGS) && wr_data[1+i];
        assign mode[i]     = outmode_e'((i == 0) ? st_q.mode0 : st_q.mode1);

        fpwm_channel #(.CNT_W(CNT_W)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick     (tick),
            .wrap     (wrap),
            .count    (count_o),
            .load_buf (load_buf[i]),
            .buf_data (wr_data),
            .mode     (mode[i]),
            .idle_lvl (st_q.idle[i]),
            .flag_clr (flag_clr[i]),
            .live_o   (live[i]),
            .wave_o   (wave_o[i]),
            .flag_o   (match_o[i])
        );

        // R8
        live_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !wrap |=> $stable(live[i]));
    end

    assign ovf_o = st_q.ovf;

    // R9
    ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> ovf_o);

    // R10
    ovf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_wr && wr_data[0] && !wrap) |=> !ovf_o);

endmodule

// File: tb/fpwm_timer_tb.sv
module fpwm_timer_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] count_o;
    logic       ovf_o;
    logic [1:0] match_o;
    logic [1:0] wave_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    fpwm_timer u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .count_o(count_o), .ovf_o(ovf_o),
        .match_o(match_o), .wave_o(wave_o)
    );

    typedef struct {
        logic [7:0] cnt;
        logic       ovf;
        logic [1:0] mf;
        logic [1:0] wave;
        logic [1:0] md0;
        logic [1:0] md1;
    } exp_t;

    exp_t sbq[$];

    // Cycle model built from the requirements
    int         m_pre;
    logic [2:0] m_sel;
    logic       m_topsel;
    logic [7:0] m_cnt;
    logic [7:0] m_stage [2];
    logic [7:0] m_live [2];
    logic [1:0] m_mode [2];
    logic       m_idle [2];
    logic       m_wave [2];
    logic       m_mf [2];
    logic       m_ovf;

    function automatic int divn(input logic [2:0] s);
        case (s)
            3'd1: return 1;
            3'd2: return 8;
            3'd3: return 32;
            3'd4: return 64;
            3'd5: return 128;
            3'd6: return 256;
            3'd7: return 1024;
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pre = 0; m_sel = 0; m_topsel = 0; m_cnt = 0; m_ovf = 0;
            for (int i = 0; i < 2; i++) begin
                m_stage[i] = 0; m_live[i] = 0; m_mode[i] = 0;
                m_idle[i] = 0; m_wave[i] = 0; m_mf[i] = 0;
            end
        end else begin
            bit tk, wr;
            logic [7:0] top;
            exp_t e;
            tk  = (m_sel != 0) && ((m_pre % divn(m_sel)) == divn(m_sel) - 1);
            top = m_topsel ? m_live[0] : 8'd255;
            wr  = tk && (m_cnt == top);
            for (int i = 0; i < 2; i++) begin
                bit hit;
                hit = tk && (m_cnt == m_live[i]);
                case (m_mode[i])
                    2'd0: m_wave[i] = m_idle[i];
                    2'd1: if (hit) m_wave[i] = ~m_wave[i];
                    2'd2: if (wr) m_wave[i] = 1; else if (hit) m_wave[i] = 0;
                    default: if (wr) m_wave[i] = 0; else if (hit) m_wave[i] = 1;
                endcase
                if (hit) m_mf[i] = 1;
                else if (wr_en && wr_addr == 3'd4 && wr_data[1+i]) m_mf[i] = 0;
                if (wr) m_live[i] = m_stage[i];
                if (wr_en && wr_addr == 3'(1+i)) m_stage[i] = wr_data;
            end
            if (wr) m_ovf = 1;
            else if (wr_en && wr_addr == 3'd4 && wr_data[0]) m_ovf = 0;
            if (tk) m_cnt = wr ? 8'd0 : m_cnt + 8'd1;
            if (wr_en && wr_addr == 3'd0) begin
                m_pre = 0; m_topsel = wr_data[0]; m_sel = wr_data[3:1];
            end else if (m_sel != 0) begin
                m_pre = (m_pre + 1) % 1024;
            end
            if (wr_en && wr_addr == 3'd3) begin
                m_mode[0] = wr_data[1:0]; m_mode[1] = wr_data[3:2];
                m_idle[0] = wr_data[4];   m_idle[1] = wr_data[5];
            end
            e.cnt = m_cnt; e.ovf = m_ovf;
            e.mf = {m_mf[1], m_mf[0]}; e.wave = {m_wave[1], m_wave[0]};
            e.md0 = m_mode[0]; e.md1 = m_mode[1];
            sbq.push_back(e);
        end
    end

    function automatic string mtag(input logic [1:0] md);
        case (md)
            2'd0: return "R7";
            2'd1: return "R6";
            2'd2: return "R4";
            default: return "R5";
        endcase
    endfunction

    // Monitor: pops predicted items and compares with the ports
    always @(negedge clk) begin
        if (rst_n && sbq.size() > 0) begin
            exp_t e;
            e = sbq.pop_front();
            checks++;
            if (count_o !== e.cnt) begin
                errors++;
                $display("FAIL R1 count act=%0d exp=%0d", count_o, e.cnt);
            end
            checks++;
            if (ovf_o !== e.ovf) begin
                errors++;
                $display("FAIL R9/R10 ovf act=%0b exp=%0b", ovf_o, e.ovf);
            end
            checks++;
            if (match_o !== e.mf) begin
                errors++;
                $display("FAIL R9/R10 match act=%b exp=%b", match_o, e.mf);
            end
            checks++;
            if (wave_o[0] !== e.wave[0]) begin
                errors++;
                $display("FAIL %s waveA act=%b exp=%b", mtag(e.md0), wave_o[0], e.wave[0]);
            end
            checks++;
            if (wave_o[1] !== e.wave[1]) begin
                errors++;
                $display("FAIL %s waveB act=%b exp=%b", mtag(e.md1), wave_o[1], e.wave[1]);
            end
        end
    end

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic chk(input string req, input int act, input int exp_v);
        checks++;
        if (act != exp_v) begin
            errors++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp_v);
        end
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #1_200_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog act=hung exp=done");
            finish_run();
        end
    end

    initial begin
        int hi, mx;
        logic [7:0] c0;
        repeat (3) @(negedge clk);
        // R11: reset state
        chk("R11 count", count_o, 0);
        chk("R11 flags", {ovf_o, match_o}, 0);
        chk("R11 wave", wave_o, 0);
        rst_n = 1'b1;
        repeat (20) @(negedge clk);
        chk("R11 stopped", count_o, 0);

        // R4 R5: straight on A, inverted on B, divide by 1
        wr(3'd3, 8'h0E);
        wr(3'd1, 8'd64);
        wr(3'd2, 8'd192);
        wr(3'd0, 8'h02);
        repeat (600) @(negedge clk);
        // R8: mid-period write, only staged
        wr(3'd1, 8'd10);
        repeat (600) @(negedge clk);
        // R6: toggle both
        wr(3'd3, 8'h05);
        repeat (600) @(negedge clk);
        // R7: hold level
        wr(3'd3, 8'h30);
        repeat (3) @(negedge clk);
        chk("R7 level", wave_o, 3);

        // R12: compare 0 spike on B
        wr(3'd3, 8'h08);
        wr(3'd2, 8'd0);
        repeat (600) @(negedge clk);
        hi = 0;
        for (int k = 0; k < 256; k++) begin
            @(negedge clk);
            if (wave_o[1]) hi++;
        end
        chk("R12 spike", hi, 1);
        // R12: compare 255 constant
        wr(3'd2, 8'd255);
        repeat (600) @(negedge clk);
        hi = 0;
        for (int k = 0; k < 256; k++) begin
            @(negedge clk);
            if (wave_o[1]) hi++;
        end
        chk("R12 constant", hi, 256);

        // R2: ceiling from channel A, A in straight mode matching at wrap
        wr(3'd3, 8'h0A);
        wr(3'd1, 8'd99);
        wr(3'd0, 8'h03);
        repeat (300) @(negedge clk);
        mx = 0;
        for (int k = 0; k < 250; k++) begin
            @(negedge clk);
            if (count_o > mx) mx = count_o;
        end
        chk("R2 ceiling", mx, 99);

        // R10: continuous clear meets every set
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'd4; wr_data = 8'h07;
        repeat (300) @(negedge clk);
        wr_en = 1'b0;
        wr(3'd0, 8'h00);
        wr(3'd4, 8'h07);
        @(negedge clk);
        chk("R10 cleared", {ovf_o, match_o}, 0);

        // R3: divide by 8 gives 10 ticks in 80 clocks
        wr(3'd0, 8'h04);
        c0 = count_o;
        repeat (80) @(negedge clk);
        chk("R3 div8", 8'(count_o - c0), 10);
        // R3: divide by 32
        wr(3'd0, 8'h06);
        c0 = count_o;
        repeat (320) @(negedge clk);
        chk("R3 div32", 8'(count_o - c0), 10);
        // R3: stop
        wr(3'd0, 8'h00);
        c0 = count_o;
        repeat (50) @(negedge clk);
        chk("R3 stop", count_o, c0);

        repeat (5) @(negedge clk);
        done = 1'b1;
        finish_run();
    end

endmodule